// File: doc/BRIEF.md
# Load/Store Address Unit

This unit turns the address fields of one load or store into two 32-bit results in a single step. The first is the address that goes to memory. The second is the updated base-register value, together with a flag that says whether it is written back. The offset is either a 12-bit immediate or a register value passed through a barrel shifter. The instruction chooses the shift kind and the shift amount. One control bit picks addition or subtraction. Two more bits pick among three forms: pre-index, post-index and plain offset.

The sum or difference is always computed. The index bit decides whether memory sees that value or the unmodified base. The writeback bits decide whether the base register takes the new value. The results are combinational and pass through an optional output register, which is on by default and gives one cycle of latency. A pipeline can use the registered form as a stage boundary. It can also disable the register and feed the address straight into its own memory stage.

Top module: `lsau_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `wb_en`, `acc_addr` and `wb_value` are all zero.
- R2: With `up` = 1 the result is base + offset; with `up` = 0 it is base − offset. Both wrap modulo 2^32.
- R3: With `pre` = 1, `acc_addr` and `wb_value` both equal the result of R2.
- R4: With `pre` = 0, `acc_addr` equals the unmodified base, and `wb_value` equals the result of R2.
- R5: `wb_en` = `in_valid` AND (NOT `pre` OR `wback`). The plain-offset form (`pre` = 1, `wback` = 0) does not write back.
- R6: With `use_reg` = 0, the offset is `imm12` zero-extended to 32 bits. `shift_kind` and `shift_amt` have no effect in this case.
- R7: With `use_reg` = 1, `shift_kind` selects the shift applied to `off_reg` by `shift_amt` (0..31):
  - 2'b00 shifts left and fills with zeros.
  - 2'b01 shifts right and fills with zeros.
- R8: `shift_kind` 2'b10 is an arithmetic right shift that fills with copies of bit 31. `shift_kind` 2'b11 passes `off_reg` through unshifted.
- R9: With `OUT_REG` = 1, the outputs reflect the inputs of the previous rising clock edge, and `out_valid` follows `in_valid` one cycle later.
- R10: A cycle with `in_valid` = 0 gives `out_valid` = 0 and `wb_en` = 0 on the next cycle. `acc_addr` and `wb_value` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| imm12 | input | 12 | Immediate offset |
| off_reg | input | 32 | Register offset value |
| use_reg | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| shift_kind | input | 2 | Shift type: 00 left, 01 logical right, 10 arithmetic right, 11 none |
| shift_amt | input | 5 | Shift amount |
| up | input | 1 | 1 adds the offset, 0 subtracts it |
| pre | input | 1 | 1 selects pre-index or offset form, 0 selects post-index form |
| wback | input | 1 | Writeback request in pre-index form |
| out_valid | output | 1 | Outputs carry a valid result |
| acc_addr | output | 32 | Memory access address |
| wb_value | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register writeback enable |

## Verification
Address generation and base writeback are produced in the same cycle from one adder. In pre-index form with writeback they must agree, and in post-index form they must differ by exactly the offset. The bench drives random combinations of `pre`, `wback` and `up` together with random shifted offsets. It then judges both outputs, and the enable, on the same sampled cycle against a reference model. Directed vectors make both forms fall on wrap-around sums, so the agreement and the difference are each seen at the edges of the address space.

// File: rtl/lsau_pkg.sv
package lsau_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 12;

  typedef enum logic [1:0] {
    SH_LSL  = 2'b00,
    SH_LSR  = 2'b01,
    SH_ASR  = 2'b10,
    SH_NONE = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/lsau_shifter.sv
module lsau_shifter
  import lsau_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         din,
  input  shift_kind_e          kind,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         dout
);
  localparam int AW = $clog2(W);

  logic [AW:0][W-1:0] lstage;
  logic [AW:0][W-1:0] rstage;
  logic               fill;

  assign fill      = (kind == SH_ASR) ? din[W-1] : 1'b0;
  assign lstage[0] = din;
  assign rstage[0] = din;

  // One stage per amount bit; stage i moves the data by 2**i positions.
  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int S = 1 << i;
    assign lstage[i+1] = amt[i] ? {lstage[i][W-1-S:0], {S{1'b0}}} : lstage[i];
    assign rstage[i+1] = amt[i] ? {{S{fill}}, rstage[i][W-1:S]}   : rstage[i];
  end

  always_comb begin
    unique case (kind)
      SH_LSL:  dout = lstage[AW];
      SH_LSR:  dout = rstage[AW];
      SH_ASR:  dout = rstage[AW];
      default: dout = din;
    endcase
  end

  always_comb begin
    if (kind == SH_ASR && din[W-1]) begin
      p_asr_sign_r8: assert (dout[W-1]) else $error("ASR lost sign");
    end
    if (amt == '0) begin
      p_zero_amt_r7: assert (dout == din) else $error("zero shift altered data");
    end
  end
endmodule

// File: rtl/lsau_offset.sv
module lsau_offset
  import lsau_pkg::*;
#(
  parameter int W   = 32,
  parameter int IW  = 12
) (
  input  logic [IW-1:0]        imm,
  input  logic [W-1:0]         rval,
  input  logic                 use_reg,
  input  shift_kind_e          kind,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         offset
);
  localparam int PAD = W - IW;

  logic [W-1:0] shifted;

  lsau_shifter #(.W(W)) u_shift (
    .din  (rval),
    .kind (kind),
    .amt  (amt),
    .dout (shifted)
  );

  assign offset = use_reg ? shifted : {{PAD{1'b0}}, imm};

  always_comb begin
    if (!use_reg) begin
      p_imm_zext_r6: assert (offset[W-1:IW] == '0) else $error("imm not zero-extended");
    end
  end
endmodule

// File: rtl/lsau_addsub.sv
module lsau_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  input  logic         up,
  output logic [W-1:0] result
);
  logic [W-1:0] operand;
  logic         cin;

  // Subtraction as base + ~offset + 1 keeps a single carry chain.
  assign operand = up ? offset : ~offset;
  assign cin     = ~up;
  assign result  = base + operand + {{(W-1){1'b0}}, cin};

  always_comb begin
    if (up) begin
      p_add_inverse_r2: assert (W'(result - offset) == base) else $error("add mismatch");
    end else begin
      p_sub_inverse_r2: assert (W'(result + offset) == base) else $error("sub mismatch");
    end
  end
endmodule

// File: rtl/lsau_top.sv
module lsau_top
  import lsau_pkg::*;
#(
  parameter int W       = DATA_W,
  parameter int IW      = IMM_W,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [W-1:0]         base,
  input  logic [IW-1:0]        imm12,
  input  logic [W-1:0]         off_reg,
  input  logic                 use_reg,
  input  logic [1:0]           shift_kind,
  input  logic [$clog2(W)-1:0] shift_amt,
  input  logic                 up,
  input  logic                 pre,
  input  logic                 wback,
  output logic                 out_valid,
  output logic [W-1:0]         acc_addr,
  output logic [W-1:0]         wb_value,
  output logic                 wb_en
);
  logic [W-1:0] offset;
  logic [W-1:0] moved;
  logic [W-1:0] addr_c;
  logic         wben_c;

  lsau_offset #(.W(W), .IW(IW)) u_off (
    .imm     (imm12),
    .rval    (off_reg),
    .use_reg (use_reg),
    .kind    (shift_kind_e'(shift_kind)),
    .amt     (shift_amt),
    .offset  (offset)
  );

  lsau_addsub #(.W(W)) u_add (
    .base   (base),
    .offset (offset),
    .up     (up),
    .result (moved)
  );

  assign addr_c = pre ? moved : base;
  assign wben_c = in_valid & (~pre | wback);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        wb_en     <= 1'b0;
        acc_addr  <= '0;
        wb_value  <= '0;
      end else begin
        out_valid <= in_valid;
        wb_en     <= wben_c;
        if (in_valid) begin
          acc_addr <= addr_c;
          wb_value <= moved;
        end
      end
    end

    p_post_base_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !pre) |=> (acc_addr == $past(base)));
    p_pre_same_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pre) |=> (acc_addr == wb_value));
    p_post_wb_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !pre) |=> wb_en);
    p_plain_nowb_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pre && !wback) |=> !wb_en);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !wb_en && $stable(acc_addr) && $stable(wb_value)));
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
  end else begin : g_comb
    assign out_valid = in_valid & ~rst;
    assign wb_en     = wben_c & ~rst;
    assign acc_addr  = rst ? '0 : addr_c;
    assign wb_value  = rst ? '0 : moved;
  end
endmodule

// File: tb/lsau_top_tb.sv
`timescale 1ns/1ps
module lsau_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] base = '0;
  logic [11:0] imm12 = '0;
  logic [31:0] off_reg = '0;
  logic        use_reg = 1'b0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic        up = 1'b0, pre = 1'b0, wback = 1'b0;
  logic        out_valid, wb_en;
  logic [31:0] acc_addr, wb_value;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lsau_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .imm12(imm12),
    .off_reg(off_reg), .use_reg(use_reg), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .up(up), .pre(pre), .wback(wback),
    .out_valid(out_valid), .acc_addr(acc_addr), .wb_value(wb_value), .wb_en(wb_en)
  );

  function automatic logic [31:0] m_shift(input logic [31:0] v, input logic [1:0] k,
                                          input logic [4:0] a);
    case (k)
      2'b00:   return v << a;
      2'b01:   return v >> a;
      2'b10:   return 32'($signed(v) >>> a);
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] m_off();
    return use_reg ? m_shift(off_reg, shift_kind, shift_amt) : {20'b0, imm12};
  endfunction

  function automatic logic [31:0] m_sum();
    return up ? base + m_off() : base - m_off();
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one valid request, check results one cycle later (R9).
  task automatic run(input string req, input logic [31:0] b, input logic [11:0] im,
                     input logic [31:0] ro, input logic ur, input logic [1:0] sk,
                     input logic [4:0] sa, input logic u, input logic p, input logic w);
    logic [31:0] e_sum, e_addr;
    logic        e_wb;
    @(negedge clk);
    in_valid = 1'b1; base = b; imm12 = im; off_reg = ro; use_reg = ur;
    shift_kind = sk; shift_amt = sa; up = u; pre = p; wback = w;
    e_sum  = m_sum();
    e_addr = p ? e_sum : b;
    e_wb   = !p || w;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {req, " R9 valid"}, 32'(out_valid), 32'd1);
    chk(acc_addr == e_addr, {req, " addr"}, acc_addr, e_addr);
    chk(wb_value == e_sum, {req, " wbval"}, wb_value, e_sum);
    chk(wb_en == e_wb, {req, " R5 wben"}, 32'(wb_en), 32'(e_wb));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk(out_valid == 0 && wb_en == 0, "R1 flags", {30'b0, out_valid, wb_en}, 0);
    chk(acc_addr == 0 && wb_value == 0, "R1 data", acc_addr | wb_value, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && acc_addr == 0, "R1 after release", acc_addr, 0);

    // R2: wrap-around add and subtract
    run("R2 add wrap",  32'hFFFF_FFFF, 12'd1, 0, 0, 2'b00, 0, 1, 1, 0);
    run("R2 sub wrap",  32'h0000_0000, 12'd1, 0, 0, 2'b00, 0, 0, 1, 1);
    // R3 pre-index with writeback, R4 post-index on wrap
    run("R3 pre wb",    32'h1000_0000, 12'hFFF, 0, 0, 2'b00, 0, 1, 1, 1);
    run("R4 post wrap", 32'hFFFF_FFF0, 12'h020, 0, 0, 2'b00, 0, 1, 0, 0);
    run("R5 plain",     32'h0000_8000, 12'h004, 0, 0, 2'b00, 0, 0, 1, 0);
    run("R5 post w1",   32'h0000_8000, 12'h004, 0, 0, 2'b00, 0, 0, 0, 1);
    // R6: shift fields ignored for immediate
    run("R6 imm ign",   32'h0000_1000, 12'h800, 32'hDEAD_BEEF, 0, 2'b10, 5'd31, 1, 1, 0);
    chk(acc_addr == 32'h0000_1800, "R6 imm zext", acc_addr, 32'h0000_1800);
    // R7 / R8: shifter corners
    run("R7 lsl31",     32'h0, 0, 32'h0000_0003, 1, 2'b00, 5'd31, 1, 1, 0);
    run("R7 lsr31",     32'h0, 0, 32'h8000_0000, 1, 2'b01, 5'd31, 1, 1, 0);
    run("R8 asr31",     32'h0, 0, 32'h8000_0000, 1, 2'b10, 5'd31, 1, 1, 0);
    chk(acc_addr == 32'hFFFF_FFFF, "R8 asr fill", acc_addr, 32'hFFFF_FFFF);
    run("R8 none",      32'h10, 0, 32'h0000_0100, 1, 2'b11, 5'd7, 1, 1, 0);
    chk(acc_addr == 32'h0000_0110, "R8 passthru", acc_addr, 32'h0000_0110);

    // R10: idle cycle holds data, clears flags
    begin
      logic [31:0] ha, hw;
      ha = acc_addr; hw = wb_value;
      @(negedge clk);
      base = 32'h1234_5678; off_reg = 32'hFFFF; use_reg = 1; pre = 0; in_valid = 0;
      @(negedge clk);
      chk(acc_addr == ha && wb_value == hw, "R10 hold", acc_addr, ha);
      chk(out_valid == 0 && wb_en == 0, "R10 flags", {30'b0, out_valid, wb_en}, 0);
    end

    // Random mix: R2..R9
    for (int i = 0; i < 400; i++) begin
      run("R2-rand", $urandom, 12'($urandom), $urandom, 1'($urandom), 2'($urandom),
          5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule